// File: doc/BRIEF.md
# I2C/SMBus Register Target

This block is the bus-facing front end of a small sensor register file. It watches SCL and SDA through a system-clock oversampler and recognises START, repeated START and STOP. It answers one 7-bit target address chosen by a strap, and it turns bus transfers into single-cycle byte strobes on a plain register port. The first byte of every write transfer loads a 7-bit register pointer. Any further written bytes are stored at that pointer. A read transfer, whether it follows a repeated START or comes as a bare read in a later transfer, returns bytes from the current pointer, most significant bit first.

The pointer advances after every data byte when `auto_inc` is high and stays put when it is low. An inactivity timer returns the engine to idle and releases SDA when SCL stays low too long; `timeout_dis` turns the timer off. When `alert_pend` is high, a read addressed to the alert response address is acknowledged. The reply byte is the block's own address with a 0 in bit 0, and a one-cycle `alert_clr` pulse is sent to the alert logic.

The engine is one state machine. ST_IDLE waits for START. ST_ADDR shifts in the address byte and goes to ST_ADDR_ACK on a match, or back to ST_IDLE on a mismatch. ST_ADDR_ACK leads to ST_PTR for a write or to ST_TX for a read. ST_PTR leads to ST_PTR_ACK and then to ST_WDATA. ST_WDATA and ST_WDATA_ACK alternate for as long as the master writes. ST_TX drives eight bits and then moves to ST_TX_ACK, which returns to ST_TX on a master ACK and to ST_IDLE on a NACK. Three events override every state: START forces ST_ADDR, while STOP and timeout force ST_IDLE.

Top module: `i2c_reg_target`

## Requirements
- R1: The target address is 0x38 when `addr_strap` is high during reset and 0x3F when it is low, and it does not change while out of reset.
- R2: The byte that follows a write address sets the pointer from its bits 6:0; bit 7 of that byte has no effect.
- R3: Each byte written after the pointer byte gives exactly one cycle of `reg_wr`, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R4: A read (address byte with bit 0 = 1) returns `reg_rdata` at the pointer, MSB first, with one `reg_rd` cycle per byte loaded. It continues while the master ACKs and stops after a NACK. `reg_wr` and `reg_rd` are never high together.
- R5: With `auto_inc` = 1 the pointer increases by one after each data byte, whether written or read. With `auto_inc` = 0 it stays fixed.
- R6: The target pulls SDA low (`sda_oe` = 1) for the ninth clock after every accepted address, pointer or write byte. `sda_oe` changes only while SCL is low, and it is 0 after reset.
- R7: After a non-matching address, the target leaves SDA released and makes no register strobe until the next START.
- R8: With `timeout_dis` = 0, SCL held low for TIMEOUT_CYCLES clocks returns the engine to idle and releases SDA. With `timeout_dis` = 1 this does not happen.
- R9: A read addressed to 0x0C is acknowledged only when `alert_pend` = 1. The reply is {own address, 0}, and one `alert_clr` pulse follows; `sda_oe` is low during that pulse.
- R10: A bare read in a later transfer, with no pointer byte, starts at the pointer left by the previous transfer.
- R11: An SDA pulse of fewer than FILT_LEN samples while SCL is high is neither a START nor a STOP and does not disturb the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous for state |
| addr_strap | input | 1 | Address select, captured while in reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| auto_inc | input | 1 | Pointer advance enable from the register file |
| timeout_dis | input | 1 | Disables the SCL-low timeout |
| alert_pend | input | 1 | An alert is waiting to be claimed |
| reg_rdata | input | 8 | Register contents at `reg_addr` |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 7 | Register pointer |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rd | output | 1 | One-cycle strobe when a byte is read |
| alert_clr | output | 1 | One-cycle pulse after an alert reply |

## Verification
A wrong state or bit count shows at the ports within one byte time. The ACK slot moves or disappears, which the master model sees on the ninth clock, and write data lands at the wrong register or read bytes come back shifted. A pointer fault stays hidden until the next data byte, and then every following byte in the sweep comes back wrong, so writing and then reading back sequential registers exposes it right away. Timeout and alert faults show as SDA still held low after the hold window, or as a missing or extra `alert_clr` pulse at the end of the reply byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_TX, ST_TX_ACK
    } tgt_state_e;

    localparam logic [6:0] DEV_ADDR_HI     = 7'h38;
    localparam logic [6:0] DEV_ADDR_LO     = 7'h3F;
    localparam logic [6:0] ALERT_RESP_ADDR = 7'h0C;
    localparam int         NUM_LINES       = 2;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // two-flop synchronizer, then a majority-free "all agree" filter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                line_o <= 1'b1;
            else if (~|hist_q)
                line_o <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_scl_timeout.sv
module i2c_scl_timeout #(
    parameter int LIMIT = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic dis,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (scl || dis) begin
                cnt_q <= '0;
            end else if (cnt_q == W'(LIMIT - 1)) begin
                cnt_q   <= '0;
                expired <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 6_000_000,
    parameter int FILT_LEN       = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_strap,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       auto_inc,
    input  logic       timeout_dis,
    input  logic       alert_pend,
    input  logic [7:0] reg_rdata,
    output logic       sda_oe,
    output logic [6:0] reg_addr,
    output logic       reg_wr,
    output logic [7:0] reg_wdata,
    output logic       reg_rd,
    output logic       alert_clr
);
    localparam int CNT_W = 4;

    tgt_state_e state, state_nx;
    logic [NUM_LINES-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f, scl_q, sda_q;
    logic rise, fall, start_ev, stop_ev, byte_done, tmo_pulse;
    logic hit_dev, hit_ara;
    logic [6:0] dev_addr, ptr_q;
    logic [7:0] sh_q, tx_q, tx_src;
    logic [CNT_W-1:0] cnt_q;
    logic rw_q, ara_q, mack_q;

    assign raw_lines = {scl_i, sda_i};
    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_filt
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(raw_lines[gi]), .line_o(filt_lines[gi]));
    end
    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    i2c_scl_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .dis(timeout_dis), .expired(tmo_pulse));

    // strap captured only while reset is held
    always_ff @(posedge clk)
        if (!rst_n) dev_addr <= addr_strap ? DEV_ADDR_HI : DEV_ADDR_LO;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign rise      = scl_f && !scl_q;
    assign fall      = !scl_f && scl_q;
    assign start_ev  = scl_f && scl_q && sda_q && !sda_f;
    assign stop_ev   = scl_f && scl_q && !sda_q && sda_f;
    assign byte_done = fall && (cnt_q == CNT_W'(8));
    assign hit_dev   = (sh_q[7:1] == dev_addr);
    assign hit_ara   = (sh_q[7:1] == ALERT_RESP_ADDR) && sh_q[0] && alert_pend;
    assign tx_src    = ara_q ? {dev_addr, 1'b0} : reg_rdata;
    assign reg_addr  = ptr_q;

    always_comb begin
        state_nx = state;
        if (tmo_pulse)     state_nx = ST_IDLE;
        else if (start_ev) state_nx = ST_ADDR;
        else if (stop_ev)  state_nx = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done) state_nx = (hit_dev || hit_ara) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (fall) state_nx = rw_q ? ST_TX : ST_PTR;
                ST_PTR:       if (byte_done) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (fall) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (fall) state_nx = ST_WDATA;
                ST_TX:        if (fall && cnt_q == CNT_W'(7)) state_nx = ST_TX_ACK;
                ST_TX_ACK:    if (fall) state_nx = (mack_q && !ara_q) ? ST_TX : ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0; sh_q <= '0; tx_q <= '0; cnt_q <= '0; ptr_q <= '0;
            rw_q <= 1'b0; ara_q <= 1'b0; mack_q <= 1'b0;
            reg_wr <= 1'b0; reg_wdata <= '0; reg_rd <= 1'b0; alert_clr <= 1'b0;
        end else begin
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            alert_clr <= 1'b0;
            if (tmo_pulse || stop_ev || start_ev) begin
                sda_oe <= 1'b0;
                cnt_q  <= '0;
                if (start_ev) ara_q <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (rise) begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (byte_done) begin
                            cnt_q <= '0;
                            if (state == ST_ADDR) begin
                                sda_oe <= hit_dev || hit_ara;
                                rw_q   <= sh_q[0];
                                ara_q  <= hit_ara && !hit_dev;
                            end else if (state == ST_PTR) begin
                                ptr_q  <= sh_q[6:0];
                                sda_oe <= 1'b1;
                            end else begin
                                reg_wr    <= 1'b1;
                                reg_wdata <= sh_q;
                                sda_oe    <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (fall) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            tx_q   <= tx_src;
                            sda_oe <= ~tx_src[7];
                            reg_rd <= !ara_q;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_PTR_ACK: if (fall) sda_oe <= 1'b0;
                    ST_WDATA_ACK: if (fall) begin
                        sda_oe <= 1'b0;
                        ptr_q  <= ptr_q + 7'(auto_inc);
                    end
                    ST_TX: if (fall) begin
                        if (cnt_q == CNT_W'(7)) begin
                            sda_oe <= 1'b0;
                        end else begin
                            tx_q   <= {tx_q[6:0], 1'b0};
                            sda_oe <= ~tx_q[6];
                            cnt_q  <= cnt_q + 1'b1;
                        end
                    end
                    ST_TX_ACK: begin
                        if (rise) begin
                            mack_q <= ~sda_f;
                            if (ara_q) alert_clr <= 1'b1;
                            else       ptr_q <= ptr_q + 7'(auto_inc);
                        end
                        if (fall) begin
                            cnt_q <= '0;
                            if (mack_q && !ara_q) begin
                                tx_q   <= reg_rdata;
                                sda_oe <= ~reg_rdata[7];
                                reg_rd <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       alert_clr,
    input logic       tmo,
    input logic [6:0] dev_addr
);
    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n) $stable(dev_addr)); // R1
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R3
    AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd)); // R4
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_f); // R6
    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) tmo |=> !sda_oe); // R8
    AST_CLR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) alert_clr |-> !sda_oe); // R9
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .alert_clr(alert_clr), .tmo(tmo_pulse), .dev_addr(dev_addr));

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;
    localparam int TO = 400;
    localparam int Q  = 16;

    logic clk = 1'b0;
    logic rst_n, strap, auto_inc, tdis, pend, scl_m, sda_m, glitch;
    logic sda_oe, reg_wr, reg_rd, alert_clr;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] regs [128];
    logic sda_line;
    int nchk = 0, nfail = 0, wr_cnt = 0, rd_cnt = 0, clr_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    i2c_reg_target #(.TIMEOUT_CYCLES(TO), .FILT_LEN(3)) uut (
        .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_i(scl_m), .sda_i(sda_line ^ glitch),
        .auto_inc(auto_inc), .timeout_dis(tdis), .alert_pend(pend), .reg_rdata(reg_rdata),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .alert_clr(alert_clr));

    always @(posedge clk) begin
        if (reg_wr) begin regs[reg_addr] <= reg_wdata; wr_cnt++; end
        if (reg_rd) rd_cnt++;
        if (alert_clr) clr_cnt++;
    end

    function automatic logic [7:0] dv(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic i_start;
        sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
    endtask
    task automatic i_rstart;
        sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
    endtask
    task automatic i_stop;
        sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input bit glt);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1; wq();
            if (glt && i == 0) begin
                glitch = 1; repeat (2) @(negedge clk); glitch = 0;
            end
            wq(); scl_m = 0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glt, output bit ack);
        send_bits(b, glt);
        sda_m = 1; wq(); scl_m = 1; wq(); ack = !sda_line; wq(); scl_m = 0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1; wq(); b[i] = sda_line; wq(); scl_m = 0;
        end
        wq(); sda_m = !ack; wq(); scl_m = 1; wq(2); scl_m = 0; wq(); sda_m = 1;
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int w0;
        for (int i = 0; i < 128; i++) regs[i] = 8'h00;
        rst_n = 0; strap = 1; auto_inc = 1; tdis = 0; pend = 0;
        scl_m = 1; sda_m = 1; glitch = 0;
        repeat (5) @(negedge clk);
        chk("R6 reset sda_oe", sda_oe, 0);
        chk("R3 reset reg_wr", reg_wr, 0);
        chk("R9 reset alert_clr", alert_clr, 0);
        rst_n = 1; repeat (10) @(negedge clk);

        // sweep: 4 writes of 8 bytes; odd blocks set pointer bit 7 (R2)
        for (int t = 0; t < 4; t++) begin
            i_start();
            send_byte(8'h70, 0, ack); chk("R1 strap-high address ack", ack, 1);
            send_byte(8'(t * 8 + ((t % 2) ? 8'h80 : 0)), 0, ack); chk("R6 pointer ack", ack, 1);
            for (int k = 0; k < 8; k++) begin
                send_byte(dv(t * 8 + k), 0, ack); chk("R3 data ack", ack, 1);
            end
            i_stop();
        end
        for (int i = 0; i < 32; i++) chk("R2 R3 R5 write sweep", regs[i], dv(i));
        chk("R2 bit7 ignored reg 0x88 path", regs[8'h48 & 7'h7F], 0);

        rd_cnt = 0;
        for (int t = 0; t < 4; t++) begin
            i_start(); send_byte(8'h70, 0, ack); send_byte(8'(t * 8), 0, ack);
            i_rstart(); send_byte(8'h71, 0, ack); chk("R4 read address ack", ack, 1);
            for (int k = 0; k < 8; k++) begin
                recv_byte(b, k != 7); chk("R4 R5 read sweep", b, dv(t * 8 + k));
            end
            i_stop();
        end
        chk("R4 read strobes", rd_cnt, 32);

        auto_inc = 0;
        i_start(); send_byte(8'h70, 0, ack); send_byte(8'h40, 0, ack);
        send_byte(8'h11, 0, ack); send_byte(8'h22, 0, ack); send_byte(8'h33, 0, ack); i_stop();
        chk("R5 fixed pointer last byte", regs[8'h40], 8'h33);
        chk("R5 fixed pointer neighbour", regs[8'h41], 8'h00);
        i_start(); send_byte(8'h71, 0, ack);
        recv_byte(b, 1); chk("R5 fixed read 1", b, 8'h33);
        recv_byte(b, 0); chk("R5 fixed read 2", b, 8'h33); i_stop();
        auto_inc = 1;

        i_start(); send_byte(8'h70, 0, ack); send_byte(8'h05, 0, ack); i_stop();
        i_start(); send_byte(8'h71, 0, ack); recv_byte(b, 0); i_stop();
        chk("R10 bare read at stored pointer", b, dv(5));
        i_start(); send_byte(8'h71, 0, ack); recv_byte(b, 0); i_stop();
        chk("R10 second bare read advanced", b, dv(6));

        w0 = wr_cnt;
        i_start(); send_byte(8'h55, 0, ack); chk("R7 mismatch no ack", ack, 0);
        send_byte(8'h03, 0, ack); chk("R7 ignored byte no ack", ack, 0);
        send_byte(8'hAA, 0, ack); i_stop();
        chk("R7 no write strobe", wr_cnt, w0);
        chk("R7 register untouched", regs[3], dv(3));

        i_start(); send_byte(8'h70, 0, ack); send_byte(8'h50, 0, ack);
        send_byte(8'hC3, 1, ack); chk("R11 ack after glitch", ack, 1); i_stop();
        chk("R11 data after glitch", regs[8'h50], 8'hC3);
        chk("R11 one write", wr_cnt, w0 + 1);

        i_start(); send_byte(8'h19, 0, ack); i_stop();
        chk("R9 no alert no ack", ack, 0);
        chk("R9 no clear", clr_cnt, 0);
        pend = 1;
        i_start(); send_byte(8'h19, 0, ack); chk("R9 alert ack", ack, 1);
        recv_byte(b, 0); i_stop();
        chk("R9 reply own address", b, 8'h70);
        chk("R9 one clear pulse", clr_cnt, 1);
        pend = 0;

        i_start(); send_bits(8'h70, 0); wq();
        chk("R6 ack held in low phase", sda_oe, 1);
        repeat (TO + 40) @(negedge clk);
        chk("R8 timeout releases", sda_oe, 0);
        i_stop();
        tdis = 1;
        i_start(); send_bits(8'h70, 0); wq();
        repeat (TO + 40) @(negedge clk);
        chk("R8 timeout disabled holds ack", sda_oe, 1);
        scl_m = 1; wq(2); scl_m = 0; wq(); i_stop();
        tdis = 0;

        rst_n = 0; strap = 0; repeat (5) @(negedge clk); rst_n = 1; repeat (10) @(negedge clk);
        i_start(); send_byte(8'h70, 0, ack); i_stop(); chk("R1 strap-low old address", ack, 0);
        i_start(); send_byte(8'h7E, 0, ack); i_stop(); chk("R1 strap-low address", ack, 1);
        pend = 1;
        i_start(); send_byte(8'h19, 0, ack); recv_byte(b, 0); i_stop();
        chk("R9 reply strap-low address", b, 8'h7E);

        done = 1;
        report();
    end
endmodule